// File: doc/BRIEF.md
# Divider Configuration Front End

This block sits ahead of the divider logic of a clock synthesizer. It produces the active configuration that the dividers use: a 9-bit feedback divide value, a 2-bit output divide select and two test-select bits. The divide values can come from a parallel pin group or from a three-wire serial port made up of data, clock and a load strobe. The test-select bits are set only through the serial port, and they choose what the TEST pin shows.

All pins are asynchronous to the system clock. Each one passes through a synchronizer chain before any edge on it is detected, so the block runs entirely in one clock domain. The parallel group has two phases. While its active-low strobe is low, the pin values pass straight through to the active configuration. When the strobe rises, the last values are held. The serial port shifts data in on each rising serial clock. Its strobe copies the shift register into the active configuration on a rising edge, and freezes that configuration when the strobe falls. While the strobe is held high, every serial clock updates the configuration directly. A serial transfer replaces values that came from the parallel group. A flag reports whether the active feedback value lies inside a lock-range window set by parameters.

Top module: `divcfg_front`

## Requirements
- R1: During and right after reset, m_out, n_out and t_out are all zero, and test_out and m_valid are low.
- R2: While par_load_n is low, m_out and n_out follow par_m and par_n. An output reflects a pin change no later than three system clock edges after it.
- R3: After par_load_n rises, m_out and n_out hold their values even when par_m and par_n change. They keep holding until par_load_n goes low again or a serial transfer occurs.
- R4: While par_load_n is high, each rising ser_clk shifts ser_data into a 13-bit shift register, most significant bit first. A complete word is sent in the order T1, T0, N1, N0, M8 down to M0. Shifting alone does not change the outputs while ser_load stays low.
- R5: A rising ser_load, seen while par_load_n is high, copies the shift register to t_out, n_out and m_out. The layout is bits 12:11 to T, bits 10:9 to N and bits 8:0 to M. After ser_load falls, further shifting leaves the outputs unchanged.
- R6: While ser_load is held high, every rising ser_clk sets the outputs to the shift register contents that include the bit just shifted.
- R7: t_out can be changed only through the serial path. Parallel mode leaves it unchanged.
- R8: test_out is low whenever par_load_n is low, whatever the value of t_out.
- R9: With par_load_n high, test_out is selected by t_out: 00 gives low, 01 gives shift register bit 12 (the last stage), 10 gives m_tc, and 11 gives high.
- R10: m_valid is high exactly when MIN_M <= m_out <= MAX_M. The defaults are 25 and 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| par_load_n | input | 1 | Active-low parallel strobe: transparent when low, held from its rising edge |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_data | input | 1 | Serial data |
| ser_clk | input | 1 | Serial shift clock, sampled on its rising edge |
| ser_load | input | 1 | Serial transfer strobe |
| m_tc | input | 1 | Terminal-count indication from the feedback divider |
| m_out | output | 9 | Active feedback divide value |
| n_out | output | 2 | Active output divide select |
| t_out | output | 2 | Active test-select bits |
| test_out | output | 1 | TEST pin output |
| m_valid | output | 1 | Active feedback value lies inside the lock-range window |

## Verification
A pin change is captured by the first synchronizer stage on one edge and reaches the last stage on the next edge. The registered configuration and the shift register then update on the third edge. m_valid and the TEST selection follow from these registers without further delay, and m_tc reaches test_out combinationally. The bench therefore holds each serial bit stable for several cycles on either side of its ser_clk edge. It samples outputs one nanosecond after the sixth clock edge that follows any pin change, and it never samples inside the three-edge window. A model of the shift register is kept in the bench and updated on each bit sent, and the values expected in the held-load mode and for the last-stage TEST selection come from that model.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
   localparam int M_W   = 9;
   localparam int N_W   = 2;
   localparam int T_W   = 2;
   localparam int CFG_W = T_W + N_W + M_W;

   // field layout of the shift word, first-shifted field on top
   typedef struct packed {
      logic [T_W-1:0] t;
      logic [N_W-1:0] n;
      logic [M_W-1:0] m;
   } cfg_t;

   typedef enum logic [T_W-1:0] {
      TSEL_LOW   = 2'b00,
      TSEL_SHIFT = 2'b01,
      TSEL_TC    = 2'b10,
      TSEL_HIGH  = 2'b11
   } tsel_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial if (STAGES < 2) $error("divcfg_sync: STAGES must be at least 2");

   logic [WIDTH-1:0] stg [STAGES];

   genvar i;
   generate
      for (i = 0; i < STAGES; i++) begin : g_stg
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= d;
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '0;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_shift.sv
module divcfg_shift
   import divcfg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pl,
   input  logic sc_rise,
   input  logic sd,
   output cfg_t sr
);
   logic shift_en;
   assign shift_en = pl & sc_rise;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        sr <= '0;
      else if (shift_en) sr <= cfg_t'({sr[CFG_W-2:0], sd});

   // R4: new bit enters at the bottom, old contents move up one place
   assert_shift_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pl && sc_rise) |=> (sr[0] == $past(sd)) && (sr[CFG_W-1:1] == $past(sr[CFG_W-2:0])));
   // R4: no serial clock edge, no movement
   assert_shift_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pl && sc_rise) |=> $stable(sr));
endmodule

// File: rtl/divcfg_active.sv
module divcfg_active
   import divcfg_pkg::*;
(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pl,
   input  logic           sl,
   input  logic           sl_rise,
   input  logic           sc_rise,
   input  logic           sd,
   input  logic [M_W-1:0] pm,
   input  logic [N_W-1:0] pn,
   input  cfg_t           sr_now,
   output cfg_t           act
);
   cfg_t sr_next;
   assign sr_next = cfg_t'({sr_now[CFG_W-2:0], sd});

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) act <= '0;
      else if (!pl) begin
         act.m <= pm;
         act.n <= pn;
      end
      else if (sl_rise)          act <= sr_now;
      else if (sl && sc_rise)    act <= sr_next;

   // R2: transparent parallel phase
   assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pl |=> (act.m == $past(pm)) && (act.n == $past(pn)));
   // R7: parallel phase never touches the test bits
   assert_par_keeps_t_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pl |=> $stable(act.t));
   // R5: rising serial strobe transfers the shift register
   assert_ser_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pl && sl_rise) |=> act == $past(sr_now));
   // R6: held strobe passes each new shift word through
   assert_ser_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pl && sl && !sl_rise && sc_rise) |=> act == $past(sr_next));
   // R3: latched state holds without a serial event
   assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pl && !sl_rise && !(sl && sc_rise)) |=> $stable(act));
endmodule

// File: rtl/divcfg_front.sv
module divcfg_front
   import divcfg_pkg::*;
#(
   parameter int MIN_M       = 25,
   parameter int MAX_M       = 31,
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           par_load_n,
   input  logic [8:0]     par_m,
   input  logic [1:0]     par_n,
   input  logic           ser_data,
   input  logic           ser_clk,
   input  logic           ser_load,
   input  logic           m_tc,
   output logic [8:0]     m_out,
   output logic [1:0]     n_out,
   output logic [1:0]     t_out,
   output logic           test_out,
   output logic           m_valid
);
   localparam int SW = 4 + M_W + N_W;
   localparam logic [M_W-1:0] MIN_V = MIN_M[M_W-1:0];
   localparam logic [M_W-1:0] MAX_V = MAX_M[M_W-1:0];

   initial begin
      if (M_W != 9 || N_W != 2 || T_W != 2) $error("divcfg_front: field widths do not match ports");
      if (MIN_M > MAX_M)                    $error("divcfg_front: empty lock window");
      if (MAX_M >= (1 << M_W) || MIN_M < 0) $error("divcfg_front: lock window outside M range");
   end

   logic [SW-1:0] raw, syn;
   assign raw = {par_load_n, ser_load, ser_clk, ser_data, par_n, par_m};

   divcfg_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

   logic           pl, sl, sc, sd;
   logic [M_W-1:0] pm;
   logic [N_W-1:0] pn;
   assign {pl, sl, sc, sd, pn, pm} = syn;

   logic sl_d, sc_d;
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         sl_d <= 1'b0;
         sc_d <= 1'b0;
      end else begin
         sl_d <= sl;
         sc_d <= sc;
      end

   logic sl_rise, sc_rise;
   assign sl_rise = sl & ~sl_d;
   assign sc_rise = sc & ~sc_d;

   cfg_t sr, act;

   divcfg_shift u_shift (
      .clk(clk), .rst_n(rst_n), .pl(pl), .sc_rise(sc_rise), .sd(sd), .sr(sr));

   divcfg_active u_act (
      .clk(clk), .rst_n(rst_n), .pl(pl), .sl(sl), .sl_rise(sl_rise),
      .sc_rise(sc_rise), .sd(sd), .pm(pm), .pn(pn), .sr_now(sr), .act(act));

   logic sel_bit;
   always_comb begin
      unique case (tsel_e'(act.t))
         TSEL_LOW:   sel_bit = 1'b0;
         TSEL_SHIFT: sel_bit = sr[CFG_W-1];
         TSEL_TC:    sel_bit = m_tc;
         TSEL_HIGH:  sel_bit = 1'b1;
         default:    sel_bit = 1'b0;
      endcase
   end

   assign m_out    = act.m;
   assign n_out    = act.n;
   assign t_out    = act.t;
   assign test_out = pl & sel_bit;
   assign m_valid  = (act.m >= MIN_V) && (act.m <= MAX_V);

   // R8: parallel mode keeps the TEST pin low
   assert_test_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !pl |-> !test_out);
   // R9: constant selections give constant levels outside parallel mode
   assert_test_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pl && t_out == 2'b11) |-> test_out);
endmodule

// File: tb/sim_divcfg_front.sv
module sim_divcfg_front;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       par_load_n = 1'b0;
   logic [8:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic       ser_data = 1'b0, ser_clk = 1'b0, ser_load = 1'b0, m_tc = 1'b0;
   logic [8:0] m_out;
   logic [1:0] n_out, t_out;
   logic       test_out, m_valid;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [12:0] srm = '0;

   always #10 clk = ~clk;

   divcfg_front u0 (
      .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .par_m(par_m), .par_n(par_n),
      .ser_data(ser_data), .ser_clk(ser_clk), .ser_load(ser_load), .m_tc(m_tc),
      .m_out(m_out), .n_out(n_out), .t_out(t_out), .test_out(test_out), .m_valid(m_valid));

   // {m, n, valid}
   localparam logic [11:0] PVEC [8] = '{
      {9'd0,   2'd0, 1'b0}, {9'd24,  2'd1, 1'b0}, {9'd25, 2'd2, 1'b1}, {9'd28, 2'd3, 1'b1},
      {9'd31,  2'd0, 1'b1}, {9'd32,  2'd1, 1'b0}, {9'd511, 2'd3, 1'b0}, {9'd256, 2'd2, 1'b0}};

   task automatic waitc(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      ser_data = b;
      waitc(4);
      ser_clk = 1'b1;
      srm = {srm[11:0], b};
      waitc(4);
      ser_clk = 1'b0;
      waitc(2);
   endtask

   task automatic send_word(input logic [1:0] t, input logic [1:0] n, input logic [8:0] m);
      logic [12:0] w;
      w = {t, n, m};
      for (int i = 12; i >= 0; i--) send_bit(w[i]);
   endtask

   task automatic pulse_load;
      ser_load = 1'b1;
      waitc(6);
      ser_load = 1'b0;
      waitc(6);
   endtask

   initial begin
      waitc(3);
      chk("R1 m_out", m_out, 0);
      chk("R1 n_out", n_out, 0);
      chk("R1 t_out", t_out, 0);
      chk("R1 test_out", test_out, 0);
      chk("R1 m_valid", m_valid, 0);
      rst_n = 1'b1;
      waitc(1);
      chk("R1 m_out after release", m_out, 0);

      // R2 R10 R8: transparent parallel loads
      for (int i = 0; i < 8; i++) begin
         par_m = PVEC[i][11:3];
         par_n = PVEC[i][2:1];
         waitc(6);
         chk("R2 m_out", m_out, int'(PVEC[i][11:3]));
         chk("R2 n_out", n_out, int'(PVEC[i][2:1]));
         chk("R10 m_valid", m_valid, int'(PVEC[i][0]));
         chk("R8 test_out parallel", test_out, 0);
      end

      // R3: latch and hold
      par_m = 9'd100; par_n = 2'd2;
      waitc(6);
      par_load_n = 1'b1;
      waitc(6);
      par_m = 9'd200; par_n = 2'd1;
      waitc(6);
      chk("R3 m_out held", m_out, 100);
      chk("R3 n_out held", n_out, 2);

      // R4: shifting alone does not change the outputs
      send_word(2'b00, 2'd3, 9'd300);
      chk("R4 m_out unchanged by shift", m_out, 100);
      chk("R4 n_out unchanged by shift", n_out, 2);
      // R5 and R3 override by serial transfer
      pulse_load;
      chk("R5 m_out transfer", m_out, 300);
      chk("R5 n_out transfer", n_out, 3);
      chk("R5 t_out transfer", t_out, 0);
      // R5: frozen after the strobe falls
      send_word(2'b00, 2'd1, 9'd27);
      chk("R5 m_out frozen", m_out, 300);
      pulse_load;
      chk("R10 m_valid serial 27", m_valid, 1);

      // R6: strobe held high, each bit passes through
      ser_load = 1'b1;
      waitc(6);
      chk("R6 m_out at rise", m_out, int'(srm[8:0]));
      begin
         logic [12:0] w;
         w = {2'b11, 2'd2, 9'd29};
         for (int i = 12; i >= 0; i--) begin
            send_bit(w[i]);
            chk("R6 m_out pass", m_out, int'(srm[8:0]));
            chk("R6 n_out pass", n_out, int'(srm[10:9]));
            chk("R6 t_out pass", t_out, int'(srm[12:11]));
         end
      end
      ser_load = 1'b0;
      waitc(6);
      chk("R9 test_out sel 11", test_out, 1);

      // R9: last-stage selection
      send_word(2'b01, 2'd0, 9'd26);
      pulse_load;
      chk("R9 test_out last stage 0", test_out, int'(srm[12]));
      send_bit(1'b1);
      chk("R9 test_out last stage 1", test_out, 1);
      // R9: terminal count selection
      send_word(2'b10, 2'd0, 9'd26);
      pulse_load;
      m_tc = 1'b0;
      waitc(1);
      chk("R9 test_out tc 0", test_out, 0);
      m_tc = 1'b1;
      waitc(1);
      chk("R9 test_out tc 1", test_out, 1);
      m_tc = 1'b0;
      send_word(2'b00, 2'd0, 9'd26);
      pulse_load;
      chk("R9 test_out sel 00", test_out, 0);

      // R7 R8: parallel mode with test bits 11
      send_word(2'b11, 2'd1, 9'd30);
      pulse_load;
      chk("R9 test_out high", test_out, 1);
      par_m = 9'd40; par_n = 2'd0;
      par_load_n = 1'b0;
      waitc(6);
      chk("R8 test_out low in parallel", test_out, 0);
      chk("R7 t_out kept", t_out, 3);
      chk("R2 m_out parallel again", m_out, 40);
      par_load_n = 1'b1;
      waitc(6);
      chk("R8 test_out after parallel", test_out, 1);

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end

   initial begin
      #4000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end
endmodule